// File: doc/BRIEF.md
# Translation Lookaside Buffer with Probe and Access-Error Capture

This block is a small fully associative translation cache. It maps virtual pages to physical pages and checks the access rights on each request. Every entry is a pair of 32-bit words. The tag word carries the virtual page number, an 8-bit address-space identifier, a page-size code and a valid bit. The data word carries the physical page number and four attribute bits. A request is translated combinationally, in the same cycle it is presented, so a hit without a fault costs no extra cycle.

Software loads and inspects entries through an eight-word register window, using an index register to pick the entry. A clear-all command drops every valid bit in one cycle. A probe command searches the buffer for a virtual page and address space, and records hit and index without raising a fault. When a request misses, or hits but breaks the entry's rights, the block raises an access error. On the next clock edge it records the faulting address and a cause word for software to read. Entry storage has no reset, so a reset leaves the loaded translations in place.

Top module: `xlat_cache`

## Requirements
- R1: Register window offsets: 0 is the entry index (the low bits are used), 1 is the tag word of the indexed entry, and 2 is the data word of the indexed entry. A write takes effect at the next clock edge. A read returns the stored word combinationally.
- R2: Reset does not change the tag or data word of any entry.
- R3: Tag word layout: bits 31:12 hold the virtual page number, 11:4 the address-space identifier, 3:2 the size code and bit 1 valid. The size code selects the page size: 0 is 4 KiB, 1 is 16 KiB, 2 is 64 KiB and 3 is 1 MiB. On a hit, lk_pa takes the data word's bits 31:12 for the page bits and lk_va's bits for the offset within the page, in the same cycle.
- R4: An entry matches when it is valid, its address-space identifier equals lk_asid, and its page number equals lk_va[31:12] on every bit above the page offset. A request with lk_valid high and no matching entry raises lk_err in the same cycle.
- R5: Data word attribute bits: bit 0 allows read (lk_kind 0), bit 1 allows write (lk_kind 1), bit 2 allows fetch (lk_kind 2), and bit 3 limits the page to supervisor requests. lk_kind 3 is always denied. A hit whose rights forbid the request raises lk_err. lk_attr shows bits 3:0 of the hit entry's data word.
- R6: At the clock edge after lk_err is high, offset 6 holds the request address. Offset 7 holds the cause word: bit 0 miss, bit 1 rights violation, bits 3:2 lk_kind, bit 4 lk_super and bit 5 set. Without lk_err, both registers keep their values.
- R7: Writing 1 to bit 0 of offset 3 clears the valid bit of every entry at the next edge. All other fields stay as they were.
- R8: Writing a word to offset 4 probes the buffer, with that word's bits 31:12 as the page and bits 11:4 as the identifier. From the next edge, offset 4 reads that word back. Offset 5 reads bit 31 as hit and the low bits as the matching index (0 on a miss). A probe never changes offsets 6 and 7.
- R9: When several entries match, the lowest index is used, both for a lookup and for a probe.
- R10: After reset, offsets 0, 4, 5, 6 and 7 read 0, and lk_err and lk_hit are low while lk_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (registers only, not entries) |
| lk_valid | input | 1 | Translation request present |
| lk_va | input | 32 | Request virtual address |
| lk_asid | input | 8 | Request address-space identifier |
| lk_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| lk_super | input | 1 | Request is from supervisor mode |
| lk_hit | output | 1 | A valid entry matches the request |
| lk_pa | output | 32 | Translated physical address (0 without a hit) |
| lk_attr | output | 4 | Attribute bits of the hit entry |
| lk_err | output | 1 | Access error: miss or rights violation |
| reg_we | input | 1 | Register window write strobe |
| reg_addr | input | 3 | Register window offset |
| reg_wdata | input | 32 | Register window write data |
| reg_rdata | output | 32 | Register window read data |

## Verification
Translation outputs (lk_hit, lk_pa, lk_attr, lk_err) belong to the cycle of the request, so the bench drives a request just after a falling edge and samples a few nanoseconds later, before the next rising edge. Fault capture, entry writes, clear-all and probe results land at the first rising edge after their cause. The bench therefore reads the matching window offset only after the following falling edge, when exactly one edge has passed. Expected values come from a bench copy of the entry contents and a bench search function, for both directed corner cases and seeded random traffic.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int WORD_W     = 32;
   localparam int PAGE_LSB   = 12;
   localparam int PN_W       = WORD_W - PAGE_LSB;
   localparam int ASID_W     = 8;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef struct packed {
      logic [PN_W-1:0]   vpn;
      logic [ASID_W-1:0] asid;
      logic [1:0]        size;
      logic              valid;
      logic              spare;
   } tag_word_t;

   typedef struct packed {
      logic [PN_W-1:0] ppn;
      logic [7:0]      spare;
      logic            sup_only;
      logic            may_x;
      logic            may_w;
      logic            may_r;
   } data_word_t;

   typedef struct packed {
      logic [25:0] spare;
      logic        logged;
      logic        sup;
      logic [1:0]  kind;
      logic        perm;
      logic        miss;
   } cause_word_t;

   // Page-number bits that belong to the in-page offset for a size code.
   function automatic logic [PN_W-1:0] offset_mask(input logic [1:0] sz);
      logic [PN_W-1:0] m;
      m = '0;
      for (int b = 0; b < 8; b++) begin
         if (b < 2 * int'(sz) + ((sz == 2'd3) ? 2 : 0)) m[b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
   import xlat_pkg::*;
(
   input  tag_word_t         tag,
   input  logic [PN_W-1:0]   vpn,
   input  logic [ASID_W-1:0] asid,
   output logic              hit
);
   logic [PN_W-1:0] keep;
   logic            pn_eq;

   always_comb begin
      keep  = ~offset_mask(tag.size);
      pn_eq = ((tag.vpn ^ vpn) & keep) == '0;
      hit   = tag.valid && (tag.asid == asid) && pn_eq;
   end
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     hits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
   import xlat_pkg::*;
(
   input  data_word_t dw,
   input  logic [1:0] kind,
   input  logic       sup,
   output logic       deny
);
   logic right_ok;

   always_comb begin
      unique case (acc_kind_e'(kind))
         ACC_READ:  right_ok = dw.may_r;
         ACC_WRITE: right_ok = dw.may_w;
         ACC_FETCH: right_ok = dw.may_x;
         default:   right_ok = 1'b0;
      endcase
      deny = !right_ok || (dw.sup_only && !sup);
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        lk_valid,
   input  logic [31:0] lk_va,
   input  logic [7:0]  lk_asid,
   input  logic [1:0]  lk_kind,
   input  logic        lk_super,
   output logic        lk_hit,
   output logic [31:0] lk_pa,
   output logic [3:0]  lk_attr,
   output logic        lk_err,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int PORTS = 2;   // 0: request lookup, 1: software probe

   initial begin
      assert (ENTRIES >= 1 && ENTRIES <= 64)
         else $fatal(1, "xlat_cache: ENTRIES must be 1..64");
      assert (IDX_W < 31)
         else $fatal(1, "xlat_cache: index too wide for probe word");
   end

   localparam logic [2:0] OFS_IDX   = 3'd0;
   localparam logic [2:0] OFS_TAG   = 3'd1;
   localparam logic [2:0] OFS_DATA  = 3'd2;
   localparam logic [2:0] OFS_CMD   = 3'd3;
   localparam logic [2:0] OFS_PRB   = 3'd4;
   localparam logic [2:0] OFS_PRES  = 3'd5;
   localparam logic [2:0] OFS_FADDR = 3'd6;
   localparam logic [2:0] OFS_FINFO = 3'd7;

   // ---------------- entry storage (no reset term) ----------------
   tag_word_t  tag_q  [ENTRIES];
   data_word_t data_q [ENTRIES];

   logic [IDX_W-1:0] idx_q;
   logic             idx_ok;
   logic             wr_tag, wr_data, clr_all, do_probe;

   always_comb begin
      idx_ok   = int'(idx_q) < ENTRIES;
      wr_tag   = reg_we && (reg_addr == OFS_TAG)  && idx_ok;
      wr_data  = reg_we && (reg_addr == OFS_DATA) && idx_ok;
      clr_all  = reg_we && (reg_addr == OFS_CMD)  && reg_wdata[0];
      do_probe = reg_we && (reg_addr == OFS_PRB);
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (clr_all) begin
            tag_q[e].valid <= 1'b0;
         end else if (wr_tag && (int'(idx_q) == e)) begin
            tag_q[e] <= tag_word_t'(reg_wdata);
         end
         if (wr_data && (int'(idx_q) == e)) begin
            data_q[e] <= data_word_t'(reg_wdata);
         end
      end
   end

   // ---------------- associative search, one per port ----------------
   logic [PN_W-1:0]   srch_vpn  [PORTS];
   logic [ASID_W-1:0] srch_asid [PORTS];
   logic [ENTRIES-1:0] srch_hits [PORTS];
   logic              srch_any  [PORTS];
   logic [IDX_W-1:0]  srch_idx  [PORTS];

   always_comb begin
      srch_vpn[0]  = lk_va[WORD_W-1:PAGE_LSB];
      srch_asid[0] = lk_asid;
      srch_vpn[1]  = reg_wdata[WORD_W-1:PAGE_LSB];
      srch_asid[1] = reg_wdata[PAGE_LSB-1:4];
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
         xlat_match u_match (
            .tag  (tag_q[e]),
            .vpn  (srch_vpn[p]),
            .asid (srch_asid[p]),
            .hit  (srch_hits[p][e])
         );
      end
      xlat_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
         .hits (srch_hits[p]),
         .any  (srch_any[p]),
         .idx  (srch_idx[p])
      );
   end

   // ---------------- translation and rights ----------------
   tag_word_t       sel_tag;
   data_word_t      sel_data;
   logic            deny;
   logic [PN_W-1:0] ofs_m;

   always_comb begin
      sel_tag  = tag_q[srch_idx[0]];
      sel_data = data_q[srch_idx[0]];
      ofs_m    = offset_mask(sel_tag.size);
   end

   xlat_perm u_perm (
      .dw   (sel_data),
      .kind (lk_kind),
      .sup  (lk_super),
      .deny (deny)
   );

   always_comb begin
      lk_hit  = lk_valid && srch_any[0];
      lk_err  = lk_valid && (!srch_any[0] || deny);
      lk_pa   = '0;
      lk_attr = '0;
      if (lk_hit) begin
         lk_pa[WORD_W-1:PAGE_LSB] = (sel_data.ppn & ~ofs_m)
                                  | (lk_va[WORD_W-1:PAGE_LSB] & ofs_m);
         lk_pa[PAGE_LSB-1:0]      = lk_va[PAGE_LSB-1:0];
         lk_attr = {sel_data.sup_only, sel_data.may_x,
                    sel_data.may_w, sel_data.may_r};
      end
   end

   // ---------------- control registers ----------------
   logic [31:0]      prb_word_q;
   logic             prb_hit_q;
   logic [IDX_W-1:0] prb_idx_q;
   logic [31:0]      flt_addr_q;
   cause_word_t      flt_info_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q      <= '0;
         prb_word_q <= '0;
         prb_hit_q  <= 1'b0;
         prb_idx_q  <= '0;
         flt_addr_q <= '0;
         flt_info_q <= '0;
      end else begin
         if (reg_we && (reg_addr == OFS_IDX)) idx_q <= reg_wdata[IDX_W-1:0];
         if (do_probe) begin
            prb_word_q <= reg_wdata;
            prb_hit_q  <= srch_any[1];
            prb_idx_q  <= srch_any[1] ? srch_idx[1] : '0;
         end
         if (lk_err) begin
            flt_addr_q        <= lk_va;
            flt_info_q        <= '0;
            flt_info_q.miss   <= !srch_any[0];
            flt_info_q.perm   <= srch_any[0] && deny;
            flt_info_q.kind   <= lk_kind;
            flt_info_q.sup    <= lk_super;
            flt_info_q.logged <= 1'b1;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_IDX:   reg_rdata[IDX_W-1:0] = idx_q;
         OFS_TAG:   if (idx_ok) reg_rdata = tag_q[idx_q];
         OFS_DATA:  if (idx_ok) reg_rdata = data_q[idx_q];
         OFS_CMD:   reg_rdata = '0;
         OFS_PRB:   reg_rdata = prb_word_q;
         OFS_PRES:  begin
            reg_rdata[31]        = prb_hit_q;
            reg_rdata[IDX_W-1:0] = prb_idx_q;
         end
         OFS_FADDR: reg_rdata = flt_addr_q;
         default:   reg_rdata = flt_info_q;
      endcase
   end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        lk_valid,
   input logic [31:0] lk_va,
   input logic [1:0]  lk_kind,
   input logic        lk_super,
   input logic        lk_hit,
   input logic [31:0] lk_pa,
   input logic [3:0]  lk_attr,
   input logic        lk_err,
   input logic        reg_we,
   input logic [2:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic [31:0] flt_addr
);
   // R3: the in-page offset below bit 12 always passes through on a hit
   assert_pa_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

   // R4: a presented request that finds no entry is an access error
   assert_miss_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_hit) |-> lk_err);

   // R5: an error-free hit must carry the right for its kind and mode
   assert_rights_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !lk_err) |->
         (((lk_kind == 2'd0) && lk_attr[0]) || ((lk_kind == 2'd1) && lk_attr[1])
          || ((lk_kind == 2'd2) && lk_attr[2])) && (lk_super || !lk_attr[3]));

   // R10: no request, no hit and no error
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_err && !lk_hit));

   // R6: the faulting address is captured at the next edge
   assert_fault_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_err |=> (flt_addr == $past(lk_va)));

   // R7: after clear-all nothing can hit
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd3 && reg_wdata[0]) |=> !lk_hit);

   // R8: a probe leaves the fault address alone
   assert_probe_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd4 && !lk_err) |=> $stable(flt_addr));
endmodule

bind xlat_cache xlat_cache_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_valid  (lk_valid),
   .lk_va     (lk_va),
   .lk_kind   (lk_kind),
   .lk_super  (lk_super),
   .lk_hit    (lk_hit),
   .lk_pa     (lk_pa),
   .lk_attr   (lk_attr),
   .lk_err    (lk_err),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .flt_addr  (flt_addr_q)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic [1:0]  lk_kind = '0;
   logic        lk_super = 1'b0;
   logic        lk_hit, lk_err;
   logic [31:0] lk_pa;
   logic [3:0]  lk_attr;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [31:0] m_tag  [N];
   logic [31:0] m_data [N];

   always #10 clk = ~clk;   // 50 MHz

   xlat_cache #(.ENTRIES(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
      .lk_asid(lk_asid), .lk_kind(lk_kind), .lk_super(lk_super),
      .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr), .lk_err(lk_err),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] size_bits(input logic [1:0] s);
      int w;
      w = (s == 2'd3) ? 8 : 2 * int'(s);
      return 20'((1 << w) - 1);
   endfunction

   // bench model: first matching index, or -1
   function automatic int m_find(input logic [19:0] vpn, input logic [7:0] asid);
      for (int e = 0; e < N; e++) begin
         logic [19:0] k;
         k = ~size_bits(m_tag[e][3:2]);
         if (m_tag[e][1] && m_tag[e][11:4] == asid
             && ((m_tag[e][31:12] & k) == (vpn & k))) return e;
      end
      return -1;
   endfunction

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic put_entry(input int i, input logic [31:0] t, input logic [31:0] d);
      wr_reg(3'd0, 32'(i));
      wr_reg(3'd1, t);
      wr_reg(3'd2, d);
      m_tag[i] = t; m_data[i] = d;
   endtask

   task automatic clear_all();
      wr_reg(3'd3, 32'h1);
      for (int e = 0; e < N; e++) m_tag[e][1] = 1'b0;
   endtask

   task automatic lookup(input string req, input logic [31:0] va, input logic [7:0] asid,
                         input logic [1:0] kind, input logic sup);
      int          e;
      logic        x_hit, x_deny, x_err;
      logic [31:0] x_pa, v, f_addr_before, f_info_before;
      logic [3:0]  x_attr;
      logic [19:0] m;
      rd_reg(3'd6, f_addr_before);
      rd_reg(3'd7, f_info_before);
      e = m_find(va[31:12], asid);
      x_hit = (e >= 0);
      x_pa = '0; x_attr = '0; x_deny = 1'b0;
      if (x_hit) begin
         m = size_bits(m_tag[e][3:2]);
         x_pa = {(m_data[e][31:12] & ~m) | (va[31:12] & m), va[11:0]};
         x_attr = m_data[e][3:0];
         x_deny = (kind == 2'd3) || (kind == 2'd0 && !x_attr[0])
                || (kind == 2'd1 && !x_attr[1]) || (kind == 2'd2 && !x_attr[2])
                || (x_attr[3] && !sup);
      end
      x_err = !x_hit || x_deny;
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_kind = kind; lk_super = sup;
      #2;
      chk({req, " hit"}, 32'(lk_hit), 32'(x_hit));
      chk({req, " pa"}, lk_pa, x_pa);
      chk({req, " attr"}, 32'(lk_attr), 32'(x_attr));
      chk({req, " err"}, 32'(lk_err), 32'(x_err));
      @(negedge clk);
      lk_valid = 1'b0;
      rd_reg(3'd6, v);
      chk("R6 fault addr", v, x_err ? va : f_addr_before);
      rd_reg(3'd7, v);
      chk("R6 fault cause", v, x_err ? {26'd0, 1'b1, sup, kind, x_hit, !x_hit}
                                     : f_info_before);
   endtask

   task automatic probe(input logic [31:0] w);
      int e;
      logic [31:0] v, fa;
      rd_reg(3'd6, fa);
      e = m_find(w[31:12], w[11:4]);
      wr_reg(3'd4, w);
      rd_reg(3'd4, v);
      chk("R8 probe word", v, w);
      rd_reg(3'd5, v);
      chk("R8 probe result", v, (e >= 0) ? (32'h8000_0000 | 32'(e)) : 32'h0);
      rd_reg(3'd6, v);
      chk("R8 probe no fault", v, fa);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] seed;
      seed = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      rd_reg(3'd0, v); chk("R10 index", v, 0);
      rd_reg(3'd4, v); chk("R10 probe word", v, 0);
      rd_reg(3'd5, v); chk("R10 probe result", v, 0);
      rd_reg(3'd6, v); chk("R10 fault addr", v, 0);
      rd_reg(3'd7, v); chk("R10 fault cause", v, 0);
      #1; chk("R10 idle err", 32'(lk_err), 0);

      for (int e = 0; e < N; e++) begin m_tag[e] = '0; m_data[e] = '0; end
      clear_all();
      for (int e = 0; e < N; e++) put_entry(e, 32'h0, 32'h0);
      // R1 load and read back
      put_entry(0, 32'h1234_5012, 32'hABCD_E007);            // 4K, asid 01, rwx
      put_entry(1, 32'h2000_0116, 32'h5550_0003);            // 16K, asid 11, rw
      put_entry(2, 32'h3000_002A, 32'h6660_0001);            // 64K, asid 02, r only
      put_entry(3, 32'h4000_001E, 32'h7770_000F);            // 1M, asid 01, sup only
      put_entry(5, 32'h3000_0022, 32'h9990_0007);            // duplicate of 2 (4K)
      for (int e = 0; e < N; e++) begin
         wr_reg(3'd0, 32'(e));
         rd_reg(3'd1, v); chk("R1 tag readback", v, m_tag[e]);
         rd_reg(3'd2, v); chk("R1 data readback", v, m_data[e]);
      end
      // R2 entries survive reset
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd_reg(3'd0, v); chk("R10 index after reset", v, 0);
      rd_reg(3'd1, v); chk("R2 tag kept", v, m_tag[0]);
      wr_reg(3'd0, 32'd3);
      rd_reg(3'd2, v); chk("R2 data kept", v, m_data[3]);

      lookup("R3 4K page", 32'h1234_5ABC, 8'h01, 2'd0, 1'b0);
      lookup("R3 16K page", 32'h2000_3FFF, 8'h11, 2'd1, 1'b0);
      lookup("R3 64K page", 32'h3000_F123, 8'h02, 2'd0, 1'b0);
      lookup("R3 1M page", 32'h400F_F456, 8'h01, 2'd2, 1'b1);
      lookup("R4 asid mismatch", 32'h1234_5000, 8'h02, 2'd0, 1'b0);
      lookup("R4 page outside", 32'h2000_4000, 8'h11, 2'd0, 1'b0);
      lookup("R5 write denied", 32'h3000_0000, 8'h02, 2'd1, 1'b0);
      lookup("R5 user on sup page", 32'h4000_0000, 8'h01, 2'd0, 1'b0);
      lookup("R5 reserved kind", 32'h1234_5000, 8'h01, 2'd3, 1'b1);
      lookup("R9 lowest index", 32'h3000_0010, 8'h02, 2'd0, 1'b0);
      probe(32'h3000_0020);   // R9 both 2 and 5 match
      probe(32'h2000_2110);
      probe(32'h5555_5010);
      // R7 clear-all
      clear_all();
      lookup("R7 miss after clear", 32'h1234_5000, 8'h01, 2'd0, 1'b0);
      wr_reg(3'd0, 32'd0);
      rd_reg(3'd1, v); chk("R7 fields kept", v, 32'h1234_5010);
      probe(32'h1234_5010);

      // random traffic
      for (int it = 0; it < 400; it++) begin
         logic [31:0] base;
         base = {12'h5A0, 8'($urandom_range(0, 3) * 16'h40), 12'h000};
         if ($urandom_range(0, 3) == 0) begin
            put_entry($urandom_range(0, N - 1),
                      {base[31:12] ^ 20'($urandom_range(0, 255)),
                       8'($urandom_range(1, 2)), 2'($urandom_range(0, 3)),
                       1'($urandom_range(0, 5) != 0), 1'b0},
                      {20'($urandom), 8'h00, 4'($urandom)});
         end else if ($urandom_range(0, 9) == 0) begin
            probe({base[31:12] ^ 20'($urandom_range(0, 255)),
                   8'($urandom_range(1, 2)), 4'h0});
         end else begin
            lookup("R4 random", base ^ {12'h0, 8'($urandom_range(0, 255)), 12'($urandom)},
                   8'($urandom_range(1, 2)), 2'($urandom_range(0, 2)),
                   1'($urandom_range(0, 1)));
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule